// File: doc/BRIEF.md
# Transmit Three-Tap Output Equalizer

This block is the digital model of one lane's transmit output equalizer. Each bit slot carries one NRZ bit, qualified by a strobe. The block maps that bit to +1 (bit value 1) or -1 (bit value 0). It then forms a weighted sum over three neighbouring bits: the following bit through a pre-cursor tap, the bit itself through the main tap, and the preceding bit through a post-cursor tap. The sum is turned into a signed drive level in millivolts.

The main tap has a fixed weight of 128. The pre-cursor and post-cursor taps have programmable weights of 0 to 128 and always subtract, so each one is a fraction between 0 and -1 of the main tap, in steps of 1/128. The sum is normalized so that the level with all taps reinforcing lands on the selected amplitude. A 4-bit amplitude code selects a swing of 200 to 950 mV peak-to-peak in 50 mV steps, which is a peak level of 100 + 25·code mV. A polarity control negates the transmitted signal. A loopback select replaces the normal data bit with the lane's looped-back received bit.

The output for a bit needs the bit after it. So a level is produced at the strobe of the following bit, and it is registered together with a valid flag. All configuration is sampled only at a strobe.

Top module: `tx_ffe_lane`

## Requirements
- R1: While reset is held and after its release, `out_mv` is 0 and `out_vld` is 0. The stored preceding and current bits both reset to +1.
- R2: For a bit with preceding bit p and following bit n, the raw value is 128·c − pre·n − post·p. Each bit maps as 1 → +1 and 0 → −1. `cfg_pre` weights the following bit and `cfg_post` weights the preceding bit.
- R3: A pre or post code above 128 acts exactly as 128.
- R4: The level is round(raw · A / (128 + pre + post)), with A = 100 + 25·`cfg_amp` mV. When both neighbours differ from the bit, the magnitude of the level equals A.
- R5: Rounding is to the nearest integer, with exact halves rounded away from zero. For example, pre=96, post=32, amp=2 with bits p=0, c=1, n=1 gives +38.
- R6: With `cfg_inv` set, the level is the negation of the non-inverted level.
- R7: With `lpbk_sel` set, `lpbk_bit` is taken as the new bit and `data_bit` is ignored. With `lpbk_sel` clear, the reverse holds.
- R8: `out_vld` is high for exactly the cycle after each cycle in which `bit_vld` is high. `out_mv` holds its value while no strobe occurs.
- R9: Changes to `cfg_pre`, `cfg_post`, `cfg_amp`, `cfg_inv` and `lpbk_sel` between strobes have no effect on the output until the next strobe. That strobe uses the values present at its own clock edge.
- R10: The level for a bit appears one clock after the strobe of the following bit. The level produced at the first strobe after reset belongs to the reset-valued current bit (+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | New bit strobe |
| data_bit | input | 1 | Normal data bit |
| lpbk_bit | input | 1 | Looped-back received bit |
| lpbk_sel | input | 1 | 1 selects the loopback bit |
| cfg_pre | input | 8 | Pre-cursor weight code, 0..128 (larger values clamp) |
| cfg_post | input | 8 | Post-cursor weight code, 0..128 (larger values clamp) |
| cfg_amp | input | 4 | Amplitude step code |
| cfg_inv | input | 1 | Polarity inversion |
| out_vld | output | 1 | Output level valid |
| out_mv | output | 11 | Signed drive level in mV |

## Verification
A strobe at clock edge k produces the level of the bit that arrived at the strobe before it. That level, and `out_vld`, are visible one clock after edge k, and there is no other register on the path. The bench drives each strobe at a falling edge. It computes the expected level from its own copy of the bit history and the configuration in force at that strobe, then samples shortly after the next rising edge. During idle stretches, it samples after every rising edge to confirm that the level is held and that the valid flag is low while the configuration is changed.

// File: rtl/ffe_pkg.sv
package ffe_pkg;

  // Map an NRZ bit to its signed symbol.
  function automatic int sym_of(input logic b);
    return b ? 1 : -1;
  endfunction

  // Limit a tap code to the largest legal weight.
  function automatic int tap_limit(input int code, input int max_code);
    return (code > max_code) ? max_code : code;
  endfunction

  // Weighted sum over the three bit positions; side taps subtract.
  function automatic int tap_sum(input int main_w, input int pre_w, input int post_w,
                                 input logic nx, input logic cu, input logic pv);
    return main_w * sym_of(cu) - pre_w * sym_of(nx) - post_w * sym_of(pv);
  endfunction

  // Peak drive level for an amplitude code.
  function automatic int peak_of(input int amp, input int base_mv, input int step_mv);
    return base_mv + step_mv * amp;
  endfunction

  // raw*peak/denom, nearest integer, ties away from zero.
  function automatic int norm_round(input int raw, input int peak, input int denom);
    int num;
    int mag;
    int q;
    num = raw * peak;
    mag = (num < 0) ? -num : num;
    q   = (mag + denom / 2) / denom;
    return (num < 0) ? -q : q;
  endfunction

endpackage

// File: rtl/ffe_src_sel.sv
module ffe_src_sel (
  input  logic data_bit,
  input  logic lpbk_bit,
  input  logic lpbk_sel,
  output logic sel_bit
);
  always_comb sel_bit = lpbk_sel ? lpbk_bit : data_bit;
endmodule

// File: rtl/ffe_history.sv
module ffe_history (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic new_bit,
  output logic cur_q,
  output logic prev_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b1;
      prev_q <= 1'b1;
    end else if (shift_en) begin
      prev_q <= cur_q;
      cur_q  <= new_bit;
    end
  end

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (cur_q == $past(new_bit) && prev_q == $past(cur_q))); // R10

  AST_HIST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> ($stable(cur_q) && $stable(prev_q))); // R9
endmodule

// File: rtl/ffe_level_calc.sv
module ffe_level_calc #(
  parameter int TAP_W   = 8,
  parameter int TAP_MAX = 128,
  parameter int AMP_W   = 4,
  parameter int BASE_MV = 100,
  parameter int STEP_MV = 25,
  parameter int OUT_W   = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TAP_W-1:0]        pre_code,
  input  logic [TAP_W-1:0]        post_code,
  input  logic [AMP_W-1:0]        amp_code,
  input  logic                    inv,
  input  logic                    nx_bit,
  input  logic                    cu_bit,
  input  logic                    pv_bit,
  output logic signed [OUT_W-1:0] level,
  output logic signed [OUT_W-1:0] peak_mv
);
  import ffe_pkg::*;

  int eff_pre;
  int eff_post;
  int denom;
  int pk;
  int raw;
  int scaled;

  always_comb begin
    eff_pre  = tap_limit(int'(pre_code), TAP_MAX);
    eff_post = tap_limit(int'(post_code), TAP_MAX);
    denom    = TAP_MAX + eff_pre + eff_post;
    pk       = peak_of(int'(amp_code), BASE_MV, STEP_MV);
    raw      = tap_sum(TAP_MAX, eff_pre, eff_post, nx_bit, cu_bit, pv_bit);
    scaled   = norm_round(raw, pk, denom);
    if (inv) scaled = -scaled;
    level    = OUT_W'(scaled);
    peak_mv  = OUT_W'(pk);
  end

  AST_FULL_SWING: assert property (@(posedge clk) disable iff (!rst_n)
    (nx_bit != cu_bit && pv_bit != cu_bit) |-> (level == peak_mv || level == -peak_mv)); // R4

  AST_TAP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pre_code) >= TAP_MAX && post_code == '0 && nx_bit == cu_bit) |-> level == '0); // R3
endmodule

// File: rtl/tx_ffe_lane.sv
module tx_ffe_lane #(
  parameter int TAP_W   = 8,
  parameter int TAP_MAX = 128,
  parameter int AMP_W   = 4,
  parameter int BASE_MV = 100,
  parameter int STEP_MV = 25,
  parameter int OUT_W   = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_vld,
  input  logic                    data_bit,
  input  logic                    lpbk_bit,
  input  logic                    lpbk_sel,
  input  logic [TAP_W-1:0]        cfg_pre,
  input  logic [TAP_W-1:0]        cfg_post,
  input  logic [AMP_W-1:0]        cfg_amp,
  input  logic                    cfg_inv,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] out_mv
);
  localparam int PEAK_MAX = BASE_MV + STEP_MV * ((1 << AMP_W) - 1);

  logic                    new_bit;
  logic                    cur_q;
  logic                    prev_q;
  logic signed [OUT_W-1:0] next_level;
  logic signed [OUT_W-1:0] cfg_peak;

  ffe_src_sel u_src (
    .data_bit (data_bit),
    .lpbk_bit (lpbk_bit),
    .lpbk_sel (lpbk_sel),
    .sel_bit  (new_bit)
  );

  ffe_history u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (bit_vld),
    .new_bit  (new_bit),
    .cur_q    (cur_q),
    .prev_q   (prev_q)
  );

  ffe_level_calc #(
    .TAP_W(TAP_W), .TAP_MAX(TAP_MAX), .AMP_W(AMP_W),
    .BASE_MV(BASE_MV), .STEP_MV(STEP_MV), .OUT_W(OUT_W)
  ) u_calc (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_code  (cfg_pre),
    .post_code (cfg_post),
    .amp_code  (cfg_amp),
    .inv       (cfg_inv),
    .nx_bit    (new_bit),
    .cu_bit    (cur_q),
    .pv_bit    (prev_q),
    .level     (next_level),
    .peak_mv   (cfg_peak)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_mv  <= '0;
    end else begin
      out_vld <= bit_vld;
      if (bit_vld) out_mv <= next_level;
    end
  end

  AST_VLD_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> out_vld); // R8

  AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> !out_vld); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(out_mv)); // R9

  AST_PEAK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mv <= OUT_W'(PEAK_MAX)) && (out_mv >= -OUT_W'(PEAK_MAX))); // R4

  AST_LEVEL_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> (out_mv <= $past(cfg_peak) && out_mv >= -$past(cfg_peak))); // R4
endmodule

// File: tb/test_tx_ffe_lane.sv
module test_tx_ffe_lane;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_vld;
  logic        data_bit;
  logic        lpbk_bit;
  logic        lpbk_sel;
  logic [7:0]  cfg_pre;
  logic [7:0]  cfg_post;
  logic [3:0]  cfg_amp;
  logic        cfg_inv;
  logic        out_vld;
  logic signed [10:0] out_mv;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;
  bit h_cur    = 1;
  bit h_prev   = 1;
  int last_lvl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_ffe_lane i_tx_ffe_lane (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .data_bit(data_bit),
    .lpbk_bit(lpbk_bit), .lpbk_sel(lpbk_sel), .cfg_pre(cfg_pre),
    .cfg_post(cfg_post), .cfg_amp(cfg_amp), .cfg_inv(cfg_inv),
    .out_vld(out_vld), .out_mv(out_mv)
  );

  function automatic int expect_lvl(int pre, int post, int amp, bit inv, bit n, bit c, bit p);
    real wp, wq, v, r;
    wp = (pre > 128) ? 128.0 : real'(pre);
    wq = (post > 128) ? 128.0 : real'(post);
    v = (128.0 * (c ? 1.0 : -1.0) + wp * (n ? -1.0 : 1.0) + wq * (p ? -1.0 : 1.0))
        * real'(100 + 25 * amp) / (128.0 + wp + wq);
    r = (v >= 0.0) ? $floor(v + 0.5) : -$floor(-v + 0.5);
    if (inv) r = -r;
    return int'(r);
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One strobe; checks the level produced by it against the bench model.
  task automatic send(input bit d, input bit lb, input string req);
    bit nb;
    int e;
    @(negedge clk);
    data_bit = d; lpbk_bit = lb; bit_vld = 1'b1;
    nb = lpbk_sel ? lb : d;
    e = expect_lvl(int'(cfg_pre), int'(cfg_post), int'(cfg_amp), cfg_inv, nb, h_cur, h_prev);
    @(posedge clk); #1;
    bit_vld = 1'b0;
    chk(int'(out_mv), e, req);
    chk(int'(out_vld), 1, {req, " R8 valid"});
    h_prev = h_cur; h_cur = nb; last_lvl = e;
  endtask

  task automatic set_cfg(input int pre, input int post, input int amp, input bit inv);
    @(negedge clk);
    cfg_pre = 8'(pre); cfg_post = 8'(post); cfg_amp = 4'(amp); cfg_inv = inv;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bit_vld = 0; data_bit = 0; lpbk_bit = 0; lpbk_sel = 0;
    cfg_pre = 0; cfg_post = 0; cfg_amp = 15; cfg_inv = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(int'(out_mv), 0, "R1 level in reset");
    chk(int'(out_vld), 0, "R1 valid in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(int'(out_mv), 0, "R1 level after release");
    // First strobe emits the reset history bit (+1) at full amplitude.
    send(1'b0, 1'b0, "R10 first output");
    chk(last_lvl, 475, "R1 reset history");
  endtask

  task automatic t_taps;
    bit seq[10] = '{1,0,0,1,1,0,1,1,1,0};
    set_cfg(20, 40, 8, 0);
    foreach (seq[i]) send(seq[i], ~seq[i], "R2 tap sum");
  endtask

  task automatic t_clamp;
    set_cfg(200, 0, 4, 0);
    send(1, 0, "R3 clamp");
    send(1, 0, "R3 clamp");
    chk(last_lvl, 0, "R3 clamp cancels");
    send(0, 0, "R3 clamp");
    send(1, 0, "R3 clamp");
    set_cfg(10, 255, 6, 0);
    send(0, 0, "R3 post clamp");
    send(1, 0, "R3 post clamp");
  endtask

  task automatic t_amp;
    for (int a = 0; a < 16; a++) begin
      set_cfg(16, 16, a, 0);
      send(1, 0, "R4 amp");
      send(0, 0, "R4 amp");
      send(1, 0, "R4 amp");
      chk(last_lvl < 0 ? -last_lvl : last_lvl, 100 + 25 * a, "R4 peak");
    end
  endtask

  task automatic t_round;
    set_cfg(96, 32, 2, 0);
    send(0, 0, "R5 round");
    send(1, 0, "R5 round");
    send(1, 0, "R5 round");
    chk(last_lvl, 38, "R5 half up");
    send(1, 0, "R5 round");
    send(0, 0, "R5 round");
    send(0, 0, "R5 round");
    chk(last_lvl, -38, "R5 half down");
  endtask

  task automatic t_inv;
    bit seq[6] = '{1,1,0,1,0,0};
    set_cfg(30, 12, 11, 1);
    foreach (seq[i]) send(seq[i], 0, "R6 invert");
    set_cfg(0, 0, 0, 1);
    send(1, 0, "R6 invert");
    send(0, 0, "R6 invert");
    chk(last_lvl, -100, "R6 negated");
    set_cfg(0, 0, 0, 0);
  endtask

  task automatic t_lpbk;
    set_cfg(0, 0, 3, 0);
    @(negedge clk); lpbk_sel = 1'b1;
    send(1, 0, "R7 loopback");
    send(0, 1, "R7 loopback");
    chk(last_lvl, -175, "R7 loopback bit taken");
    send(0, 1, "R7 loopback");
    chk(last_lvl, 175, "R7 loopback bit taken");
    @(negedge clk); lpbk_sel = 1'b0;
    send(0, 1, "R7 normal");
    chk(last_lvl, 175, "R7 normal ignores loopback");
    send(0, 1, "R7 normal");
    chk(last_lvl, -175, "R7 normal bit taken");
  endtask

  task automatic t_hold;
    int held;
    set_cfg(40, 8, 9, 0);
    send(1, 0, "R9 hold");
    send(0, 0, "R9 hold");
    held = int'(out_mv);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cfg_amp = 4'(k); cfg_inv = k[0]; cfg_pre = 8'(k * 20); lpbk_sel = k[1];
      @(posedge clk); #1;
      chk(int'(out_mv), held, "R9 level held");
      chk(int'(out_vld), 0, "R8 valid low idle");
    end
    @(negedge clk); lpbk_sel = 1'b0; cfg_amp = 4'd12; cfg_inv = 1'b1; cfg_pre = 8'd64;
    send(1, 0, "R9 new config at strobe");
    cfg_inv = 1'b0;
  endtask

  task automatic t_latency;
    set_cfg(0, 0, 0, 0);
    send(0, 0, "R10 latency");
    send(1, 0, "R10 latency");
    chk(last_lvl, -100, "R10 previous bit out");
    send(0, 0, "R10 latency");
    chk(last_lvl, 100, "R10 previous bit out");
  endtask

  initial begin
    t_reset;
    t_taps;
    t_clamp;
    t_amp;
    t_round;
    t_inv;
    t_lpbk;
    t_hold;
    t_latency;
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule